// File: doc/BRIEF.md
# Optical Black Line Clamp

This block takes a raw 10-bit sensor pixel stream and removes its black-level offset one line at a time. Each line begins with a few pixels that sit under the sensor's light shield. The bench or upstream logic flags them with a window input. The block sums sixteen of these shielded samples to get that line's dark estimate. It then folds the estimate into a running black level with a first-order recursive filter, so that the level stays steady from line to line. The pixels that follow on the same line have the running level subtracted from them, and any result below zero is forced to zero.

The recursion weight is k = 1 − 2^−n, where n is a 3-bit shift input. The running level carries four fraction bits below the pixel LSB. The first complete window after reset loads the level directly. A line whose window holds fewer than sixteen shielded samples leaves the level as it was. The clamped stream comes out two cycles after the input, with its valid and line-start markers delayed by the same amount.

Top module: `ob_black_clamp`

## Requirements
- R1: While reset is held and on the first cycle after it, out_valid and out_sol are 0 and black_level is 0.
- R2: Each input cycle with in_valid=1 produces exactly one output cycle with out_valid=1, two clock edges later. out_sol on that cycle equals in_sol of the input cycle. out_valid is 0 in every other cycle.
- R3: out_pix = in_pix − black_level when in_pix ≥ black_level, and 0 otherwise. The result is 10 bits wide. black_level is the value held on the edge where the pixel reaches the second stage.
- R4: A line's dark mean is the sum of the first 16 valid pixels with in_ob=1 after the line-start pixel, divided by 16 and truncated. The line-start pixel counts if it has in_ob=1. Shielded pixels beyond the 16th are ignored.
- R5: Let S be the 14-bit running level, with black_level = S[13:4], and let m be the dark mean. On an update, S becomes S − (S >> n) + ((m·16) >> n), where n = cfg_shift at the closing pixel. n = 0 makes the level equal m.
- R6: The first update after reset sets S = m·16 for any n.
- R7: A line whose window ends with fewer than 16 shielded samples leaves black_level unchanged.
- R8: An update happens on the first valid pixel with in_ob=0 and in_sol=0 that follows shielded pixels on the same line. That pixel and all later ones use the new level. black_level shows the new value from the next cycle on.
- R9: black_level changes only on the edge that accepts a closing pixel as defined in R8. A window cut short by a new line start is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel qualifier |
| in_sol | input | 1 | First pixel of a line |
| in_ob | input | 1 | Pixel lies in the shielded window |
| in_pix | input | 10 | Raw pixel value |
| cfg_shift | input | 3 | Recursion shift n (k = 1 − 2^−n) |
| out_valid | output | 1 | Output pixel qualifier |
| out_sol | output | 1 | Delayed line-start marker |
| out_pix | output | 10 | Clamped pixel value |
| black_level | output | 10 | Integer part of the running level |

## Verification
The bench builds the block with its default parameters: 10-bit pixels, 16 samples per window, 4 guard bits and a 3-bit shift. With these values the shift settings 0 through 7 can be exercised, including shift 7, where almost no weight goes to the new line. They also bring a full-scale shielded value of 1023 and truncation of a non-integer mean within reach. Short, long and interrupted windows are run under the same settings. So are pixels below the level, which must clamp to zero, and equal to it.

// File: rtl/ob_clamp_pkg.sv
package ob_clamp_pkg;

    typedef enum logic [1:0] {
        WIN_IDLE    = 2'd0,
        WIN_COLLECT = 2'd1,
        WIN_CLOSED  = 2'd2
    } win_phase_e;

endpackage

// File: rtl/ob_sample_accum.sv
module ob_sample_accum
    import ob_clamp_pkg::*;
#(
    parameter int PIX_W    = 10,
    parameter int CNT_LOG2 = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             px_valid,
    input  logic             px_sol,
    input  logic             px_ob,
    input  logic [PIX_W-1:0] px_data,
    output logic             close_evt,
    output logic             win_full,
    output logic [PIX_W-1:0] win_mean
);

    localparam int NSAMP = 1 << CNT_LOG2;
    localparam int CNT_W = CNT_LOG2 + 1;
    localparam int ACC_W = PIX_W + CNT_LOG2;

    typedef struct packed {
        win_phase_e       phase;
        logic [CNT_W-1:0] cnt;
        logic [ACC_W-1:0] acc;
    } acc_state_t;

    acc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (px_valid) begin
            if (px_sol) begin
                st_d.phase = WIN_IDLE;
                st_d.cnt   = '0;
                st_d.acc   = '0;
            end
            if (px_ob) begin
                if (st_d.phase != WIN_CLOSED) begin
                    st_d.phase = WIN_COLLECT;
                    if (st_d.cnt < CNT_W'(NSAMP)) begin
                        st_d.acc = st_d.acc + ACC_W'(px_data);
                        st_d.cnt = st_d.cnt + 1'b1;
                    end
                end
            end else if (st_d.phase == WIN_COLLECT) begin
                st_d.phase = WIN_CLOSED;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: WIN_IDLE, cnt: '0, acc: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign close_evt = px_valid && !px_ob && !px_sol && (st_q.phase == WIN_COLLECT);
    assign win_full  = (st_q.cnt == CNT_W'(NSAMP));
    assign win_mean  = st_q.acc[ACC_W-1:CNT_LOG2];

endmodule

// File: rtl/ob_level_filter.sv
module ob_level_filter #(
    parameter int PIX_W   = 10,
    parameter int GUARD_W = 4,
    parameter int SHIFT_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               upd_evt,
    input  logic               upd_full,
    input  logic [PIX_W-1:0]   upd_mean,
    input  logic [SHIFT_W-1:0] cfg_shift,
    output logic [PIX_W-1:0]   level
);

    localparam int S_W = PIX_W + GUARD_W;

    typedef struct packed {
        logic           primed;
        logic [S_W-1:0] acc;
    } lvl_state_t;

    lvl_state_t     st_d, st_q;
    logic [S_W-1:0] mean_fx;
    logic [S_W-1:0] decay;
    logic [S_W-1:0] inject;
    logic [S_W-1:0] blended;

    always_comb begin
        mean_fx = S_W'(upd_mean) << GUARD_W;
        decay   = st_q.acc >> cfg_shift;
        inject  = mean_fx >> cfg_shift;
        blended = (st_q.acc - decay) + inject;
        st_d    = st_q;
        if (upd_evt && upd_full) begin
            st_d.primed = 1'b1;
            st_d.acc    = st_q.primed ? blended : mean_fx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level = st_q.acc[S_W-1:GUARD_W];

endmodule

// File: rtl/ob_clamp_pipe.sv
module ob_clamp_pipe #(
    parameter int PIX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sol,
    input  logic [PIX_W-1:0] in_pix,
    input  logic [PIX_W-1:0] black,
    output logic             out_valid,
    output logic             out_sol,
    output logic [PIX_W-1:0] out_pix
);

    typedef struct packed {
        logic             v;
        logic             sol;
        logic [PIX_W-1:0] pix;
    } stage_t;

    stage_t         s1_d, s1_q, s2_d, s2_q;
    logic [PIX_W:0] diff;

    always_comb begin
        s1_d.v   = in_valid;
        s1_d.sol = in_valid && in_sol;
        s1_d.pix = in_valid ? in_pix : s1_q.pix;

        diff     = {1'b0, s1_q.pix} - {1'b0, black};
        s2_d.v   = s1_q.v;
        s2_d.sol = s1_q.sol;
        s2_d.pix = s2_q.pix;
        if (s1_q.v) begin
            s2_d.pix = diff[PIX_W] ? '0 : diff[PIX_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign out_valid = s2_q.v;
    assign out_sol   = s2_q.sol;
    assign out_pix   = s2_q.pix;

endmodule

// File: rtl/ob_black_clamp.sv
module ob_black_clamp #(
    parameter int PIX_W    = 10,
    parameter int CNT_LOG2 = 4,
    parameter int GUARD_W  = 4,
    parameter int SHIFT_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_sol,
    input  logic               in_ob,
    input  logic [PIX_W-1:0]   in_pix,
    input  logic [SHIFT_W-1:0] cfg_shift,
    output logic               out_valid,
    output logic               out_sol,
    output logic [PIX_W-1:0]   out_pix,
    output logic [PIX_W-1:0]   black_level
);

    logic             close_evt;
    logic             win_full;
    logic [PIX_W-1:0] win_mean;

    ob_sample_accum #(
        .PIX_W   (PIX_W),
        .CNT_LOG2(CNT_LOG2)
    ) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .px_valid (in_valid),
        .px_sol   (in_sol),
        .px_ob    (in_ob),
        .px_data  (in_pix),
        .close_evt(close_evt),
        .win_full (win_full),
        .win_mean (win_mean)
    );

    ob_level_filter #(
        .PIX_W  (PIX_W),
        .GUARD_W(GUARD_W),
        .SHIFT_W(SHIFT_W)
    ) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_evt  (close_evt),
        .upd_full (win_full),
        .upd_mean (win_mean),
        .cfg_shift(cfg_shift),
        .level    (black_level)
    );

    ob_clamp_pipe #(
        .PIX_W(PIX_W)
    ) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sol   (in_sol),
        .in_pix   (in_pix),
        .black    (black_level),
        .out_valid(out_valid),
        .out_sol  (out_sol),
        .out_pix  (out_pix)
    );

endmodule

// File: rtl/ob_black_clamp_chk.sv
module ob_black_clamp_chk #(
    parameter int PIX_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_sol,
    input logic             in_ob,
    input logic [PIX_W-1:0] in_pix,
    input logic             out_valid,
    input logic             out_sol,
    input logic [PIX_W-1:0] out_pix,
    input logic [PIX_W-1:0] black_level
);

    logic [1:0] warm_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm_q <= 2'd0;
        end else if (warm_q != 2'd3) begin
            warm_q <= warm_q + 2'd1;
        end
    end

    // R2
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

    // R2
    sol_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q >= 2'd2 && out_valid) |-> (out_sol == $past(in_sol, 2)));

    // R3
    never_brighter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q >= 2'd2 && out_valid) |-> (out_pix <= $past(in_pix, 2)));

    // R9
    level_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q >= 2'd1 && black_level != $past(black_level))
            |-> $past(in_valid && !in_ob && !in_sol));

    // R1
    idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid) |-> (!out_sol));

endmodule

bind ob_black_clamp ob_black_clamp_chk #(
    .PIX_W(PIX_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_sol     (in_sol),
    .in_ob      (in_ob),
    .in_pix     (in_pix),
    .out_valid  (out_valid),
    .out_sol    (out_sol),
    .out_pix    (out_pix),
    .black_level(black_level)
);

// File: tb/ob_black_clamp_tb_top.sv
module ob_black_clamp_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_sol = 1'b0;
    logic       in_ob = 1'b0;
    logic [9:0] in_pix = '0;
    logic [2:0] cfg_shift = '0;
    logic       out_valid;
    logic       out_sol;
    logic [9:0] out_pix;
    logic [9:0] black_level;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    // expected output queue
    logic [9:0] q_pix [0:1023];
    logic       q_sol [0:1023];
    int         q_cyc [0:1023];
    int         wr = 0;
    int         rd = 0;

    // requirement model
    int m_phase = 0;
    int m_cnt = 0;
    int m_acc = 0;
    int m_s = 0;
    bit m_primed = 1'b0;

    // shift, count, shield value, active value, expected level
    localparam logic [37:0] LINES [8] = '{
        {3'd2, 5'd16, 10'd64,   10'd200,  10'd64},
        {3'd2, 5'd16, 10'd128,  10'd200,  10'd80},
        {3'd0, 5'd16, 10'd100,  10'd100,  10'd100},
        {3'd3, 5'd16, 10'd20,   10'd95,   10'd90},
        {3'd3, 5'd10, 10'd500,  10'd50,   10'd90},
        {3'd1, 5'd16, 10'd10,   10'd300,  10'd50},
        {3'd7, 5'd20, 10'd1023, 10'd1023, 10'd57},
        {3'd4, 5'd16, 10'd0,    10'd30,   10'd54}
    };

    always #10 clk = ~clk;

    ob_black_clamp dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_sol     (in_sol),
        .in_ob      (in_ob),
        .in_pix     (in_pix),
        .cfg_shift  (cfg_shift),
        .out_valid  (out_valid),
        .out_sol    (out_sol),
        .out_pix    (out_pix),
        .black_level(black_level)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 50000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired act %0d exp below %0d", cyc, 50000);
            summary();
            $finish;
        end
    end

    // output scoreboard, R2 and R3
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                n_chk++;
                if (rd == wr) begin
                    n_bad++;
                    $display("FAIL R2 unexpected output act pix %0d exp none", out_pix);
                end else begin
                    if (q_cyc[rd % 1024] != cyc || q_sol[rd % 1024] != out_sol) begin
                        n_bad++;
                        $display("FAIL R2 timing/sol act cyc %0d sol %0d exp cyc %0d sol %0d",
                                 cyc, out_sol, q_cyc[rd % 1024], q_sol[rd % 1024]);
                    end
                    if (q_pix[rd % 1024] != out_pix) begin
                        n_bad++;
                        $display("FAIL R3 pixel act %0d exp %0d", out_pix, q_pix[rd % 1024]);
                    end
                    rd++;
                end
            end else if (rd != wr && q_cyc[rd % 1024] <= cyc) begin
                n_chk++;
                n_bad++;
                $display("FAIL R2 missing output act none exp pix %0d", q_pix[rd % 1024]);
                rd++;
            end
        end
    end

    task automatic check_val(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act %0d exp %0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_phase = 0;
        m_cnt = 0;
        m_acc = 0;
        m_s = 0;
        m_primed = 1'b0;
    endtask

    task automatic drive_px(bit sol, bit ob, int pix);
        int lvl;
        int m;
        @(negedge clk);
        in_valid = 1'b1;
        in_sol = sol;
        in_ob = ob;
        in_pix = 10'(pix);
        if (sol) begin
            m_phase = 0;
            m_cnt = 0;
            m_acc = 0;
        end
        if (ob) begin
            if (m_phase != 2) begin
                m_phase = 1;
                if (m_cnt < 16) begin
                    m_acc += pix;
                    m_cnt++;
                end
            end
        end else if (m_phase == 1) begin
            m_phase = 2;
            if (m_cnt == 16) begin
                m = m_acc / 16;
                if (!m_primed) m_s = m * 16;
                else m_s = m_s - (m_s >> cfg_shift) + ((m * 16) >> cfg_shift);
                m_primed = 1'b1;
            end
        end
        lvl = m_s / 16;
        q_pix[wr % 1024] = (pix > lvl) ? 10'(pix - lvl) : 10'd0;
        q_sol[wr % 1024] = sol;
        q_cyc[wr % 1024] = cyc + 2;
        wr++;
    endtask

    task automatic drive_idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_sol = 1'b0;
            in_ob = 1'b0;
        end
    endtask

    task automatic run_line(int nob, int obv, int actv);
        for (int i = 0; i < nob; i++) drive_px(i == 0, 1'b1, obv);
        for (int i = 0; i < 8; i++) drive_px(nob == 0 && i == 0, 1'b0, actv);
        drive_idle(3);
    endtask

    initial begin
        drive_idle(2);
        // R1: reset state
        check_val("R1 out_valid in reset", int'(out_valid), 0);
        check_val("R1 black_level in reset", int'(black_level), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_val("R1 out_valid after reset", int'(out_valid), 0);
        check_val("R1 out_sol after reset", int'(out_sol), 0);
        check_val("R1 black_level after reset", int'(black_level), 0);

        // table walk: R5, R6, R7, R4 (overlong window in row 6)
        for (int r = 0; r < 8; r++) begin
            @(negedge clk);
            cfg_shift = LINES[r][37:35];
            run_line(int'(LINES[r][34:30]), int'(LINES[r][29:20]), int'(LINES[r][19:10]));
            check_val("R5/R6/R7 level after table line", int'(black_level), int'(LINES[r][9:0]));
            check_val("R5 model agrees with table", m_s / 16, int'(LINES[r][9:0]));
        end

        // R9: window cut short by a new line start is dropped
        @(negedge clk);
        cfg_shift = 3'd0;
        for (int i = 0; i < 16; i++) drive_px(i == 0, 1'b1, 900);
        for (int i = 0; i < 4; i++) drive_px(i == 0, 1'b1, 5);
        drive_idle(3);
        check_val("R9 interrupted window kept level", int'(black_level), 54);

        // R4 truncating mean and R8 update timing
        for (int i = 0; i < 16; i++) drive_px(i == 0, 1'b1, i);
        check_val("R8 level before closing pixel", int'(black_level), 54);
        drive_px(1'b0, 1'b0, 20);
        @(negedge clk);
        in_valid = 1'b0;
        check_val("R8 R4 level right after closing pixel", int'(black_level), 7);
        drive_px(1'b0, 1'b0, 3);
        drive_idle(3);

        // R1 and R6 after a second reset
        rst_n = 1'b0;
        model_reset();
        drive_idle(2);
        check_val("R1 black_level in second reset", int'(black_level), 0);
        rst_n = 1'b1;
        @(negedge clk);
        cfg_shift = 3'd7;
        run_line(16, 300, 290);
        check_val("R6 first line loads directly", int'(black_level), 300);

        drive_idle(4);
        check_val("R2 all outputs seen", rd, wr);
        summary();
        $finish;
    end

endmodule